// File: doc/BRIEF.md
# DMA Sync-Driven Transfer Tracker

This block sits on the host side of a low-pin-count bus DMA engine and follows the data phase of one DMA cycle byte by byte. Each time the bus logic captures a peripheral's sync nibble, it pulses a strobe that carries the nibble and the data byte tied to it. The block uses these nibbles to decide four things: whether the cycle continues, whether it stops early, whether the internal request to the legacy DMA controller stays raised, and whether a received byte goes to memory. For a host-to-peripheral read the nibble follows the host's byte. For a peripheral-to-host write it precedes the peripheral's byte. In both cases the nibble and its byte arrive on the same strobe, so "the strobe's byte" is the byte a code refers to.

A cycle begins with a one-cycle start pulse. The start pulse latches the indicated size (one or two bytes), the direction, a verify flag and a 16-bit-channel flag. Completion is reported with a one-cycle done pulse, which the DMA controller uses to step its address and count. A 16-bit write that ends after its first byte gets its upper byte padded with a filler value. The padded write still counts as a complete transfer.

Top module: `dma_sync_tracker`

## Requirements
- R1: After reset, dmaReq, memWrEn, xferDone and errFlag are all 0.
- R2: While no cycle is open, dmaReq is set one clock after reqIn is high and then holds. Between a start pulse and the done pulse, reqIn has no effect on dmaReq.
- R3: Sync code 4'b1001 (more data) on the last byte of the indicated size produces a one-cycle xferDone in the clock after the strobe. dmaReq stays high.
- R4: Sync code 4'b0000 (ready, no error) ends the cycle after the strobe's byte. dmaReq goes low together with xferDone.
- R5: Sync code 4'b1010 (ready with error) ends the cycle like 4'b0000, drops dmaReq and sets errFlag.
- R6: Any other sync code is a wait. It writes nothing, raises no done pulse and does not advance the byte position.
- R7: On a non-verify write (dirWrite=1), every ready strobe gives a one-cycle memWrEn in the next clock with memWrData equal to the strobe's byte. memWrLane is 0 for the first byte and 1 for the second.
- R8: An end code on byte 0 of a two-byte read (xferSize=1) finishes at once: xferDone, dmaReq low, and no second byte is expected.
- R9: An end code on byte 0 of a two-byte non-verify write writes lane 0. In the following clock it writes lane 1 with PAD_BYTE (default 8'hFF) and pulses xferDone.
- R10: With verifyMode=1 the cycle runs like a write, but memWrEn never rises. That includes the padding write.
- R11: An end code (4'b0000 or 4'b1010) on byte 0 with wideChan=1 sets errFlag.
- R12: errFlag stays set until the next start pulse, which clears it one clock later.
- R13: A read (dirWrite=0) never raises memWrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | 1 | Peripheral request level, used only between cycles |
| cycleStart | input | 1 | One-cycle pulse opening a DMA data phase |
| xferSize | input | 1 | 0 = one byte, 1 = two bytes |
| dirWrite | input | 1 | 1 = peripheral to host, 0 = host to peripheral |
| verifyMode | input | 1 | 1 = verify cycle, no memory writes |
| wideChan | input | 1 | 1 = 16-bit DMA channel |
| syncValid | input | 1 | Strobe: syncCode and dataIn are valid |
| syncCode | input | 4 | Sync nibble from the peripheral |
| dataIn | input | 8 | Byte tied to the strobe |
| dmaReq | output | 1 | Internal request to the DMA controller |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Byte to write |
| memWrLane | output | 1 | Byte lane of the write |
| xferDone | output | 1 | One-cycle transfer-complete pulse |
| errFlag | output | 1 | Error seen in the current or last cycle |

## Verification
A byte position stuck at or jumping past its true value shows up within one strobe. The lane on memWrEn is wrong, or xferDone fires one byte early or late. A wrong end decision shows up in the clock right after the terminating strobe, as a dmaReq level that differs from the code sent. A missed padding state appears one clock later, as a missing lane-1 write or a missing done pulse. An error flag that fails to latch or fails to clear is visible on errFlag at the next strobe or start pulse.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam int SYNC_W = 4;
  localparam logic [SYNC_W-1:0] SYNC_DONE  = 4'b0000;
  localparam logic [SYNC_W-1:0] SYNC_FAULT = 4'b1010;
  localparam logic [SYNC_W-1:0] SYNC_MORE  = 4'b1001;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAD    = 2'd2
  } phase_t;

  typedef struct packed {
    logic commitByte;
    logic commitLane;
    logic padByte;
    logic finish;
    logic dropReq;
    logic sampleReq;
    logic setErr;
    logic clearErr;
  } strobe_t;
endpackage

// File: rtl/dst_ctrl.sv
module dst_ctrl
  import dst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStart,
  input  logic              xferSize,
  input  logic              dirWrite,
  input  logic              verifyMode,
  input  logic              wideChan,
  input  logic              syncValid,
  input  logic [SYNC_W-1:0] syncCode,
  output strobe_t           stb
);
  phase_t phase, phaseNext;
  logic   byteIdx, byteIdxNext;
  logic   cfgTwo, cfgWrite, cfgVerify, cfgWide;

  logic isEnd, isMore, isReady, atLast, earlyEnd, storeOn;

  always_comb begin
    isEnd   = (syncCode == SYNC_DONE) || (syncCode == SYNC_FAULT);
    isMore  = (syncCode == SYNC_MORE);
    isReady = syncValid && (isEnd || isMore);
    atLast  = (byteIdx == cfgTwo);
    earlyEnd = isEnd && !atLast;
    storeOn = cfgWrite && !cfgVerify;
  end

  always_comb begin
    stb         = '0;
    phaseNext   = phase;
    byteIdxNext = byteIdx;
    unique case (phase)
      ST_IDLE: begin
        stb.sampleReq = 1'b1;
        if (cycleStart) begin
          stb.clearErr = 1'b1;
          byteIdxNext  = 1'b0;
          phaseNext    = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (isReady) begin
          stb.commitByte = storeOn;
          stb.commitLane = byteIdx;
          stb.setErr     = (syncCode == SYNC_FAULT) ||
                           (isEnd && cfgWide && (byteIdx == 1'b0));
          if (earlyEnd && storeOn) begin
            phaseNext = ST_PAD;
          end else if (isEnd || atLast) begin
            stb.finish  = 1'b1;
            stb.dropReq = isEnd;
            phaseNext   = ST_IDLE;
          end else begin
            byteIdxNext = byteIdx + 1'b1;
          end
        end
      end
      ST_PAD: begin
        stb.padByte = 1'b1;
        stb.finish  = 1'b1;
        stb.dropReq = 1'b1;
        phaseNext   = ST_IDLE;
      end
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      byteIdx   <= 1'b0;
      cfgTwo    <= 1'b0;
      cfgWrite  <= 1'b0;
      cfgVerify <= 1'b0;
      cfgWide   <= 1'b0;
    end else begin
      phase   <= phaseNext;
      byteIdx <= byteIdxNext;
      if (phase == ST_IDLE && cycleStart) begin
        cfgTwo    <= xferSize;
        cfgWrite  <= dirWrite;
        cfgVerify <= verifyMode;
        cfgWide   <= wideChan;
      end
    end
  end

  AST_WAIT_HOLDS_POS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_ACTIVE && !isReady) |=> $stable(byteIdx)); // R6
  AST_PAD_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_PAD) |-> ($past(phase) == ST_ACTIVE)); // R9
  AST_FAULT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_ACTIVE && syncValid && syncCode == SYNC_FAULT) |=> (phase != ST_ACTIVE)); // R5
endmodule

// File: rtl/dst_datapath.sv
module dst_datapath
  import dst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PAD_BYTE = '1
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              reqIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dmaReq,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrLane,
  output logic              xferDone,
  output logic              errFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaReq    <= 1'b0;
      memWrEn   <= 1'b0;
      memWrData <= '0;
      memWrLane <= 1'b0;
      xferDone  <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      memWrEn  <= stb.commitByte || stb.padByte && !stb.sampleReq && stb.finish && padAllowed;
      xferDone <= stb.finish;
      if (stb.commitByte) begin
        memWrData <= dataIn;
        memWrLane <= stb.commitLane;
      end else if (stb.padByte && padAllowed) begin
        memWrData <= PAD_BYTE;
        memWrLane <= 1'b1;
      end
      if (stb.dropReq)        dmaReq <= 1'b0;
      else if (stb.sampleReq) dmaReq <= dmaReq || reqIn;
      if (stb.clearErr)       errFlag <= 1'b0;
      else if (stb.setErr)    errFlag <= 1'b1;
    end
  end

  logic padAllowed;
  assign padAllowed = 1'b1;

  AST_DROP_LOWERS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropReq |=> !dmaReq); // R4
  AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !stb.clearErr) |=> errFlag); // R12
endmodule

// File: rtl/dma_sync_tracker.sv
module dma_sync_tracker
  import dst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PAD_BYTE = '1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  input  logic              cycleStart,
  input  logic              xferSize,
  input  logic              dirWrite,
  input  logic              verifyMode,
  input  logic              wideChan,
  input  logic              syncValid,
  input  logic [SYNC_W-1:0] syncCode,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dmaReq,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrLane,
  output logic              xferDone,
  output logic              errFlag
);
  strobe_t stb;

  dst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .xferSize(xferSize),
    .dirWrite(dirWrite), .verifyMode(verifyMode), .wideChan(wideChan),
    .syncValid(syncValid), .syncCode(syncCode), .stb(stb)
  );

  dst_datapath #(.DATA_W(DATA_W), .PAD_BYTE(PAD_BYTE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqIn(reqIn), .dataIn(dataIn),
    .dmaReq(dmaReq), .memWrEn(memWrEn), .memWrData(memWrData),
    .memWrLane(memWrLane), .xferDone(xferDone), .errFlag(errFlag)
  );
endmodule

// File: tb/dma_sync_tracker_bench.sv
module dma_sync_tracker_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIn = 1'b0, cycleStart = 1'b0, xferSize = 1'b0, dirWrite = 1'b0;
  logic verifyMode = 1'b0, wideChan = 1'b0, syncValid = 1'b0;
  logic [3:0] syncCode = 4'h6;
  logic [7:0] dataIn = 8'h00;
  logic dmaReq, memWrEn, memWrLane, xferDone, errFlag;
  logic [7:0] memWrData;
  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_sync_tracker u_dma_sync_tracker (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .cycleStart(cycleStart),
    .xferSize(xferSize), .dirWrite(dirWrite), .verifyMode(verifyMode),
    .wideChan(wideChan), .syncValid(syncValid), .syncCode(syncCode),
    .dataIn(dataIn), .dmaReq(dmaReq), .memWrEn(memWrEn),
    .memWrData(memWrData), .memWrLane(memWrLane), .xferDone(xferDone),
    .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic raiseReq();
    @(negedge clk); reqIn = 1'b1;
    @(negedge clk); reqIn = 1'b0;
  endtask

  task automatic startCycle(input logic two, input logic wr, input logic ver, input logic wide);
    @(negedge clk);
    cycleStart = 1'b1; xferSize = two; dirWrite = wr; verifyMode = ver; wideChan = wide;
    @(negedge clk);
    cycleStart = 1'b0;
  endtask

  task automatic sendSync(input logic [3:0] code, input logic [7:0] data);
    syncValid = 1'b1; syncCode = code; dataIn = data;
    @(negedge clk);
    syncValid = 1'b0; syncCode = 4'h6;
  endtask

  task automatic t_reset();
    check("R1 dmaReq", {7'd0, dmaReq}, 8'd0);
    check("R1 memWrEn", {7'd0, memWrEn}, 8'd0);
    check("R1 xferDone", {7'd0, xferDone}, 8'd0);
    check("R1 errFlag", {7'd0, errFlag}, 8'd0);
  endtask

  task automatic t_writeMore();
    raiseReq();
    check("R2 req raised", {7'd0, dmaReq}, 8'd1);
    startCycle(1'b0, 1'b1, 1'b0, 1'b0);
    reqIn = 1'b0;
    sendSync(4'b1001, 8'hA5);
    check("R7 wr en", {7'd0, memWrEn}, 8'd1);
    check("R7 wr data", memWrData, 8'hA5);
    check("R7 lane0", {7'd0, memWrLane}, 8'd0);
    check("R3 done", {7'd0, xferDone}, 8'd1);
    check("R2 req held", {7'd0, dmaReq}, 8'd1);
    @(negedge clk);
    check("R3 done pulse", {7'd0, xferDone}, 8'd0);
    check("R3 req kept", {7'd0, dmaReq}, 8'd1);
  endtask

  task automatic t_waitThenEnd();
    startCycle(1'b1, 1'b1, 1'b0, 1'b0);
    sendSync(4'b0110, 8'h77);
    check("R6 no write", {7'd0, memWrEn}, 8'd0);
    check("R6 no done", {7'd0, xferDone}, 8'd0);
    sendSync(4'b1001, 8'h11);
    check("R6 lane still 0", {7'd0, memWrLane}, 8'd0);
    check("R7 data b0", memWrData, 8'h11);
    check("R3 not last", {7'd0, xferDone}, 8'd0);
    sendSync(4'b0000, 8'h22);
    check("R7 lane1", {7'd0, memWrLane}, 8'd1);
    check("R7 data b1", memWrData, 8'h22);
    check("R4 done", {7'd0, xferDone}, 8'd1);
    check("R4 req low", {7'd0, dmaReq}, 8'd0);
    check("R4 no err", {7'd0, errFlag}, 8'd0);
  endtask

  task automatic t_readEarly();
    raiseReq();
    startCycle(1'b1, 1'b0, 1'b0, 1'b0);
    sendSync(4'b0000, 8'h33);
    check("R13 read no write", {7'd0, memWrEn}, 8'd0);
    check("R8 early done", {7'd0, xferDone}, 8'd1);
    check("R8 req low", {7'd0, dmaReq}, 8'd0);
    @(negedge clk);
    check("R8 single pulse", {7'd0, xferDone}, 8'd0);
  endtask

  task automatic t_writePad();
    raiseReq();
    startCycle(1'b1, 1'b1, 1'b0, 1'b1);
    sendSync(4'b0000, 8'h5A);
    check("R9 lane0 write", {7'd0, memWrEn}, 8'd1);
    check("R9 lane0 data", memWrData, 8'h5A);
    check("R9 no done yet", {7'd0, xferDone}, 8'd0);
    check("R11 wide err", {7'd0, errFlag}, 8'd1);
    @(negedge clk);
    check("R9 pad write", {7'd0, memWrEn}, 8'd1);
    check("R9 pad lane", {7'd0, memWrLane}, 8'd1);
    check("R9 pad data", memWrData, 8'hFF);
    check("R9 done", {7'd0, xferDone}, 8'd1);
    check("R9 req low", {7'd0, dmaReq}, 8'd0);
  endtask

  task automatic t_faultClear();
    check("R12 err held", {7'd0, errFlag}, 8'd1);
    raiseReq();
    startCycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R12 err cleared", {7'd0, errFlag}, 8'd0);
    sendSync(4'b1010, 8'h00);
    check("R5 done", {7'd0, xferDone}, 8'd1);
    check("R5 err", {7'd0, errFlag}, 8'd1);
    check("R5 req low", {7'd0, dmaReq}, 8'd0);
  endtask

  task automatic t_verify();
    raiseReq();
    startCycle(1'b1, 1'b1, 1'b1, 1'b0);
    sendSync(4'b1001, 8'h44);
    check("R10 no write b0", {7'd0, memWrEn}, 8'd0);
    sendSync(4'b1001, 8'h55);
    check("R10 no write b1", {7'd0, memWrEn}, 8'd0);
    check("R10 done", {7'd0, xferDone}, 8'd1);
    check("R10 req kept", {7'd0, dmaReq}, 8'd1);
    startCycle(1'b1, 1'b1, 1'b1, 1'b0);
    sendSync(4'b0000, 8'h66);
    check("R10 early no write", {7'd0, memWrEn}, 8'd0);
    check("R10 early done", {7'd0, xferDone}, 8'd1);
    @(negedge clk);
    check("R10 no pad write", {7'd0, memWrEn}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_writeMore();
    t_waitThenEnd();
    t_readEarly();
    t_writePad();
    t_faultClear();
    t_verify();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule